// File: doc/BRIEF.md
# Credit-Based Reconfiguration Data Controller

This block is the register front end of a partial-reconfiguration engine. A host on a 64-bit register port first resets the engine through a request/acknowledge handshake. It then picks a 3-bit target region and opens a session. Configuration words are streamed into a data register, paced by a credit count that reports how many queue slots are free. At the end the host marks the push as finished and waits for the hardware to drop the session bit, which serves as the completion acknowledge. Sticky error flags are then read and cleared by writing ones.

Behind the registers sits a word queue that can be inferred as block RAM. A downstream consumer drains it through a valid/ready pair. Three pulse inputs let the back end report an operation fault, a CRC fault and an incompatible image. Protocol misuse and overflow are detected by the block itself.

Top module: `reconfig_data_ctrl`

## Requirements
- R1: After synchronous reset the status word (0x10) reads credit 256 in bits 8:0 and zero elsewhere, control (0x08) and error (0x20) read 0, and `cons_valid` is 0.
- R2: Writing control bit 0 = 1 makes control bit 4 read 1 from the cycle after. While bit 0 is held, the queue is flushed, credit returns to 256 and bits 12/13 clear. Region ID and error flags are kept. Writing bit 0 = 0 drops bit 4 a cycle later.
- R3: Control bits 9:7 hold the region ID written by the host and read back unchanged.
- R4: Writing control bit 12 = 1 (with bit 0 = 0) opens a session. Bit 12 and status bit 16 then read 1.
- R5: A data write (0x18) during an open session queues bits 31:0 and lowers credit by one. Each `cons_valid && cons_ready` cycle delivers the oldest word on `cons_data` and raises credit by one.
- R6: Writing control bit 13 = 1 during a session marks the push finished. Once the queue is empty the block clears bits 12 and 13.
- R7: A data write while bit 12 is 0, bit 13 is 1 or bit 0 is 1 sets error bit 3 and the word is dropped: credit does not move and the word is never delivered.
- R8: A data write when credit is 0 sets error bit 4. The word is dropped and the queued words come out intact and in order.
- R9: Error bits (0 operation, 1 CRC, 2 incompatible image, 3 protocol, 4 overflow) are sticky. The inputs `op_err_in`, `crc_err_in` and `image_err_in` set bits 0, 1 and 2. Writing 1 to a bit of 0x20 clears it, and a set in the same cycle wins over the clear.
- R10: Status bit 16 reads 1 while a session is open or any error bit is set, and 0 otherwise.
- R11: Status bits 22:20 give the controller state: 0 idle, 1 in reset, 2 loading, 3 draining. Bits 27:24 give host-side state as {error latched, queue not empty, finished, session open}, where 0 means idle.
- R12: A read returns data on `reg_rdata` with `reg_rvalid` high exactly one cycle later. Offset 0x00 returns the header parameter, 0xA8 and 0xB0 return the two interface-ID parameters, and 0x18 and unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid one cycle after the strobe |
| reg_rvalid | output | 1 | Read data valid |
| cons_valid | output | 1 | Queue head word available |
| cons_data | output | 32 | Queue head word |
| cons_ready | input | 1 | Consumer takes the head word |
| op_err_in | input | 1 | Operation fault pulse |
| crc_err_in | input | 1 | CRC fault pulse |
| image_err_in | input | 1 | Incompatible-image pulse |

## Verification
The hardest state to reach from the ports is a completely full queue: the credit reads 0, the next write overflows, and the queued contents must still come out unharmed. The stimulus holds `cons_ready` low and pushes 256 words back to back. It confirms zero credit, pushes one extra word, and then releases the consumer. The reference queue checks every delivered word on every clock. The same stall is used to show that a reset request flushes a part-filled queue while the region and the errors survive.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam logic [7:0] OFF_HDR   = 8'h00;
  localparam logic [7:0] OFF_CTRL  = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_DATA  = 8'h18;
  localparam logic [7:0] OFF_ERR   = 8'h20;
  localparam logic [7:0] OFF_IDLO  = 8'hA8;
  localparam logic [7:0] OFF_IDHI  = 8'hB0;

  localparam int CB_RST    = 0;
  localparam int CB_ACK    = 4;
  localparam int CB_RGN_LO = 7;
  localparam int CB_START  = 12;
  localparam int CB_FINISH = 13;
  localparam int RGN_W     = 3;
  localparam int ERR_W     = 5;

  localparam int EB_OP    = 0;
  localparam int EB_CRC   = 1;
  localparam int EB_IMAGE = 2;
  localparam int EB_PROTO = 3;
  localparam int EB_OVF   = 4;

  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_RESET = 3'd1,
    CS_LOAD  = 3'd2,
    CS_DRAIN = 3'd3
  } ctrl_state_e;
endpackage

// File: rtl/rdc_word_fifo.sv
module rdc_word_fifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0] mem_cnt;
  logic             pop, load;

  assign pop  = out_valid && pop_ready;
  assign load = (mem_cnt != '0) && (!out_valid || pop);

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      mem_cnt   <= '0;
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (load) rd_ptr <= rd_ptr + 1'b1;
      mem_cnt <= mem_cnt + CNT_W'(push) - CNT_W'(load);
      count   <= count + CNT_W'(push) - CNT_W'(pop);
      if (load)     out_valid <= 1'b1;
      else if (pop) out_valid <= 1'b0;
    end
  end

  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != CNT_W'(DEPTH))); // R8
  AST_VALID_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (count != '0)); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(flush) |-> (count == $past(count) || count == $past(count) + 1'b1 ||
                       count == $past(count) - 1'b1)); // R5
endmodule

// File: rtl/rdc_session.sv
module rdc_session
  import rdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic             wr_rst,
  input  logic             wr_start,
  input  logic             wr_finish,
  input  logic [RGN_W-1:0] wr_region,
  input  logic             q_empty,
  output logic             rst_req,
  output logic             rst_ack,
  output logic             start,
  output logic             finish,
  output logic [RGN_W-1:0] region
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      rst_ack <= 1'b0;
      start   <= 1'b0;
      finish  <= 1'b0;
      region  <= '0;
    end else begin
      rst_ack <= rst_req;
      if (ctrl_wr) begin
        rst_req <= wr_rst;
        region  <= wr_region;
      end
      if (rst_req) begin
        start  <= 1'b0;
        finish <= 1'b0;
      end else if (finish && q_empty) begin
        start  <= 1'b0;
        finish <= 1'b0;
      end else if (ctrl_wr && !wr_rst) begin
        if (wr_start && !start) start  <= 1'b1;
        if (wr_finish && start) finish <= 1'b1;
      end
    end
  end

  AST_FINISH_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    finish |-> start); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (finish && q_empty) |=> !start); // R6
endmodule

// File: rtl/reconfig_data_ctrl.sv
module reconfig_data_ctrl
  import rdc_pkg::*;
#(
  parameter int          DEPTH       = 256,
  parameter logic [63:0] HEADER_VAL  = 64'h1000_0000_0000_0005,
  parameter logic [63:0] IFACE_ID_LO = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] IFACE_ID_HI = 64'hFEDC_BA98_7654_3210,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        reg_rvalid,
  output logic        cons_valid,
  output logic [31:0] cons_data,
  input  logic        cons_ready,
  input  logic        op_err_in,
  input  logic        crc_err_in,
  input  logic        image_err_in
);
  logic             ctrl_wr, data_wr, err_wr;
  logic             rst_req, rst_ack, start, finish;
  logic [RGN_W-1:0] region;
  logic [CNT_W-1:0] fifo_cnt, credit;
  logic             q_empty, q_full, proto_bad, push;
  logic [ERR_W-1:0] err_q, err_set;
  ctrl_state_e      ctrl_st;
  logic [63:0]      ctrl_w, stat_w, rd_mux;
  logic             unused_hi;

  assign unused_hi = ^reg_wdata[63:32];
  assign ctrl_wr   = reg_wr && (reg_addr == OFF_CTRL);
  assign data_wr   = reg_wr && (reg_addr == OFF_DATA);
  assign err_wr    = reg_wr && (reg_addr == OFF_ERR);

  assign q_empty   = (fifo_cnt == '0);
  assign q_full    = (fifo_cnt == CNT_W'(DEPTH));
  assign credit    = CNT_W'(DEPTH) - fifo_cnt;
  assign proto_bad = rst_req || !start || finish;
  assign push      = data_wr && !proto_bad && !q_full;

  rdc_session u_session (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .wr_rst    (reg_wdata[CB_RST]),
    .wr_start  (reg_wdata[CB_START]),
    .wr_finish (reg_wdata[CB_FINISH]),
    .wr_region (reg_wdata[CB_RGN_LO +: RGN_W]),
    .q_empty   (q_empty),
    .rst_req   (rst_req),
    .rst_ack   (rst_ack),
    .start     (start),
    .finish    (finish),
    .region    (region)
  );

  rdc_word_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (rst_req),
    .push      (push),
    .push_data (reg_wdata[31:0]),
    .pop_ready (cons_ready),
    .out_valid (cons_valid),
    .out_data  (cons_data),
    .count     (fifo_cnt)
  );

  // sticky error flags; a new set beats a simultaneous clear
  always_comb begin
    err_set           = '0;
    err_set[EB_OP]    = op_err_in;
    err_set[EB_CRC]   = crc_err_in;
    err_set[EB_IMAGE] = image_err_in;
    err_set[EB_PROTO] = data_wr && proto_bad;
    err_set[EB_OVF]   = data_wr && !proto_bad && q_full;
  end

  always_ff @(posedge clk) begin
    if (rst)         err_q <= '0;
    else if (err_wr) err_q <= (err_q & ~reg_wdata[ERR_W-1:0]) | err_set;
    else             err_q <= err_q | err_set;
  end

  always_comb begin
    if (rst_req)     ctrl_st = CS_RESET;
    else if (finish) ctrl_st = CS_DRAIN;
    else if (start)  ctrl_st = CS_LOAD;
    else             ctrl_st = CS_IDLE;
  end

  always_comb begin
    ctrl_w                       = '0;
    ctrl_w[CB_RST]               = rst_req;
    ctrl_w[CB_ACK]               = rst_ack;
    ctrl_w[CB_RGN_LO +: RGN_W]   = region;
    ctrl_w[CB_START]             = start;
    ctrl_w[CB_FINISH]            = finish;
    stat_w                       = '0;
    stat_w[8:0]                  = 9'(credit);
    stat_w[16]                   = start || (|err_q);
    stat_w[22:20]                = ctrl_st;
    stat_w[27:24]                = {|err_q, !q_empty, finish, start};
  end

  always_comb begin
    case (reg_addr)
      OFF_HDR:  rd_mux = HEADER_VAL;
      OFF_CTRL: rd_mux = ctrl_w;
      OFF_STAT: rd_mux = stat_w;
      OFF_ERR:  rd_mux = 64'(err_q);
      OFF_IDLO: rd_mux = IFACE_ID_LO;
      OFF_IDHI: rd_mux = IFACE_ID_HI;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  AST_ACK_FLUSHED: assert property (@(posedge clk) disable iff (rst)
    rst_ack |-> (q_empty && !start && !cons_valid)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|(~err_q & $past(err_q))) |-> $past(err_wr)); // R9
  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (data_wr && proto_bad && !rst_req && !(cons_valid && cons_ready))
    |=> (fifo_cnt == $past(fifo_cnt))); // R7
  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (start || (|err_q)) |-> stat_w[16]); // R10
endmodule

// File: tb/reconfig_data_ctrl_bench.sv
module reconfig_data_ctrl_bench;
  localparam int          DEPTH = 256;
  localparam logic [63:0] HDR   = 64'h1000_0000_0000_0005;
  localparam logic [63:0] IDLO  = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] IDHI  = 64'hFEDC_BA98_7654_3210;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        reg_rvalid, cons_valid;
  logic [31:0] cons_data;
  logic        cons_ready = 1'b0;
  logic        op_err_in = 1'b0, crc_err_in = 1'b0, image_err_in = 1'b0;

  always #2.5 clk = ~clk;

  reconfig_data_ctrl u_reconfig_data_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .cons_valid(cons_valid), .cons_data(cons_data), .cons_ready(cons_ready),
    .op_err_in(op_err_in), .crc_err_in(crc_err_in), .image_err_in(image_err_in));

  int checks = 0;
  int errors = 0;

  // reference model state
  logic        m_start, m_finish, m_rst, m_ack;
  logic [2:0]  m_region;
  logic [4:0]  m_err;
  logic [31:0] q[$];
  logic        pend = 1'b0;
  logic [63:0] exp_rd;
  string       cur_tag = "R12";
  string       pend_tag;
  logic        cv_s = 1'b0;
  logic [31:0] cd_s = '0;
  logic [31:0] word_n = 32'hA500_0000;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_read(input logic [7:0] a);
    logic [63:0] v = '0;
    logic [2:0]  cs;
    case (a)
      8'h00: v = HDR;
      8'h08: begin
        v[0] = m_rst; v[4] = m_ack; v[9:7] = m_region; v[12] = m_start; v[13] = m_finish;
      end
      8'h10: begin
        cs = m_rst ? 3'd1 : m_finish ? 3'd3 : m_start ? 3'd2 : 3'd0;
        v[8:0]   = 9'(DEPTH - q.size());
        v[16]    = m_start || (m_err != 0);
        v[22:20] = cs;
        v[27:24] = {m_err != 0, q.size() != 0, m_finish, m_start};
      end
      8'h20: v = 64'(m_err);
      8'hA8: v = IDLO;
      8'hB0: v = IDHI;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(negedge clk) begin
    if (pend) begin
      chk(reg_rvalid === 1'b1, "R12 rvalid", 64'(reg_rvalid), 64'd1);
      chk(reg_rdata === exp_rd, pend_tag, reg_rdata, exp_rd);
    end else if (!rst) begin
      chk(reg_rvalid === 1'b0, "R12 no rvalid", 64'(reg_rvalid), 64'd0);
    end
    cv_s = cons_valid;
    cd_s = cons_data;
    if (!rst) chk(!(cv_s && q.size() == 0), "R5 valid with empty model", 64'(cv_s), 64'd0);
  end

  always @(posedge clk) begin
    if (rst) begin
      m_start = 0; m_finish = 0; m_rst = 0; m_ack = 0; m_region = 0; m_err = 0;
      q.delete(); pend = 0;
    end else begin
      logic pre_start, pre_finish, pre_rst;
      int   pre_size;
      logic [4:0] set;
      pre_start = m_start; pre_finish = m_finish; pre_rst = m_rst; pre_size = q.size();
      pend = reg_rd;
      if (reg_rd) begin exp_rd = model_read(reg_addr); pend_tag = cur_tag; end
      if (cv_s && cons_ready && !pre_rst) begin
        if (q.size() != 0) begin
          chk(cd_s === q[0], "R5 delivered word", 64'(cd_s), 64'(q[0]));
          void'(q.pop_front());
        end
      end
      set = {1'b0, 1'b0, image_err_in, crc_err_in, op_err_in};
      if (reg_wr && reg_addr == 8'h18) begin
        if (pre_rst || !pre_start || pre_finish) set[3] = 1'b1;
        else if (pre_size == DEPTH) set[4] = 1'b1;
        else q.push_back(reg_wdata[31:0]);
      end
      if (reg_wr && reg_addr == 8'h20) m_err = (m_err & ~reg_wdata[4:0]) | set;
      else m_err = m_err | set;
      m_ack = pre_rst;
      if (reg_wr && reg_addr == 8'h08) begin m_rst = reg_wdata[0]; m_region = reg_wdata[9:7]; end
      if (pre_rst) begin m_start = 0; m_finish = 0; q.delete(); end
      else if (pre_finish && pre_size == 0) begin m_start = 0; m_finish = 0; end
      else if (reg_wr && reg_addr == 8'h08 && !reg_wdata[0]) begin
        if (reg_wdata[12] && !pre_start) m_start = 1;
        if (reg_wdata[13] && pre_start) m_finish = 1;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk); reg_rd = 1; reg_addr = a; cur_tag = tag;
    @(negedge clk); reg_rd = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); reg_wr = 1; reg_addr = 8'h18; reg_wdata = {32'hDEAD_BEEF, word_n};
      word_n++;
    end
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic ctrl(input bit r, input bit s, input bit f, input logic [2:0] rg);
    logic [63:0] d = '0;
    d[0] = r; d[12] = s; d[13] = f; d[9:7] = rg;
    wr(8'h08, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(4); rst = 0;
    chk(cons_valid === 1'b0, "R1 cons_valid", 64'(cons_valid), 64'd0);
    rd(8'h10, "R1 status"); rd(8'h08, "R1 ctrl"); rd(8'h20, "R1 err");
    rd(8'h00, "R12 header"); rd(8'hA8, "R12 id lo"); rd(8'hB0, "R12 id hi");
    rd(8'h40, "R12 unmapped"); rd(8'h18, "R12 data reads 0");
    // write with no session: protocol error, dropped
    push_words(1); idle(3);
    rd(8'h20, "R7 proto idle"); rd(8'h10, "R10 busy on error");
    wr(8'h20, 64'h1F); rd(8'h10, "R10 idle after clear");
    // error inputs and W1C
    @(negedge clk); op_err_in = 1; crc_err_in = 1;
    @(negedge clk); op_err_in = 0; crc_err_in = 0;
    rd(8'h20, "R9 inputs set");
    wr(8'h20, 64'h2); rd(8'h20, "R9 partial clear");
    @(negedge clk); image_err_in = 1; reg_wr = 1; reg_addr = 8'h20; reg_wdata = 64'h1F;
    @(negedge clk); image_err_in = 0; reg_wr = 0;
    rd(8'h20, "R9 set beats clear");
    wr(8'h20, 64'h1F);
    // reset handshake, region
    ctrl(1, 0, 0, 3'd5); rd(8'h08, "R2 ack high"); rd(8'h10, "R11 reset state");
    ctrl(0, 0, 0, 3'd5); idle(2); rd(8'h08, "R3 region readback");
    // session with data flow
    ctrl(0, 1, 0, 3'd5); rd(8'h08, "R4 start"); rd(8'h10, "R4 busy");
    push_words(5); rd(8'h10, "R5 credit 251"); rd(8'h10, "R11 loading state");
    cons_ready = 1; idle(12); rd(8'h10, "R5 credit restored");
    cons_ready = 0; push_words(3);
    ctrl(0, 1, 1, 3'd5); rd(8'h08, "R6 finish set"); rd(8'h10, "R11 draining");
    push_words(1); rd(8'h20, "R7 proto after finish"); rd(8'h10, "R7 credit unchanged");
    cons_ready = 1; idle(12); rd(8'h08, "R6 start cleared"); wr(8'h20, 64'h1F);
    // fill to overflow
    cons_ready = 0; ctrl(0, 1, 0, 3'd2);
    push_words(DEPTH); rd(8'h10, "R8 credit zero");
    push_words(1); rd(8'h20, "R8 overflow flag");
    cons_ready = 1; idle(DEPTH + 20); rd(8'h10, "R8 drained");
    ctrl(0, 1, 1, 3'd2); idle(4); rd(8'h08, "R6 done"); wr(8'h20, 64'h1F);
    // reset mid-session keeps region and errors
    cons_ready = 0; ctrl(0, 1, 0, 3'd6); push_words(4);
    @(negedge clk); crc_err_in = 1; @(negedge clk); crc_err_in = 0;
    ctrl(1, 0, 0, 3'd6); rd(8'h10, "R2 flushed credit");
    rd(8'h20, "R2 errors kept"); ctrl(0, 0, 0, 3'd6); idle(2);
    rd(8'h08, "R2 ack dropped"); cons_ready = 1; idle(4);
    chk(cons_valid === 1'b0, "R2 nothing delivered", 64'(cons_valid), 64'd0);
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule